// File: doc/BRIEF.md
# Timestamp seconds extension unit

A packet timestamp captured by the MAC carries the full nanoseconds count but only a few low bits of seconds. This unit rebuilds a full seconds value from such a capture. It takes the bits above the truncated field from the live seconds count of the time counter. It also repairs the case where the live count has crossed into a new field period since the capture was taken.

The capture arrives as two 32-bit words with a strobe. The first word holds the nanoseconds in its low bits and the low part of the truncated seconds field in its top bits. The second word holds the high part of that field and a flag that marks the capture as present. One clock after an accepted capture, the unit presents full seconds, nanoseconds and a valid pulse.

Top module: `ts_sec_extend`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `ext_vld` is 0 and `ext_sec` and `ext_ns` are 0.
- R2: `ext_ns` equals bits [29:0] of `cap_w0` from the accepted capture, unchanged.
- R3: The 6-bit truncated field is `{cap_w1[3:0], cap_w0[31:30]}`, with `cap_w1[3:0]` placed as the upper four bits.
- R4: If field bit 5 is clear, or `live_sec` bit 5 is set, `ext_sec` is `live_sec[47:6]` concatenated above the 6-bit field.
- R5: If field bit 5 is set and `live_sec` bit 5 is clear, `ext_sec` is that concatenation minus 64.
- R6: `ext_vld` pulses high in the cycle after a clock edge at which `cap_stb` is 1 and `cap_w1[31]` is 1. It is low after every other edge.
- R7: A strobe with `cap_w1[31]` at 0, or a cycle without a strobe, leaves `ext_sec` and `ext_ns` at their previous values.
- R8: Bits [30:4] of `cap_w1` have no effect on any output.
- R9: The R5 subtraction wraps modulo 2^48 when `live_sec[47:6]` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cap_stb | input | 1 | Capture words are offered this cycle |
| cap_w0 | input | 32 | Nanoseconds [29:0] and field low bits [31:30] |
| cap_w1 | input | 32 | Field high bits [3:0] and present flag [31] |
| live_sec | input | 48 | Current seconds from the time counter |
| ext_vld | output | 1 | Rebuilt timestamp valid |
| ext_sec | output | 48 | Rebuilt full seconds |
| ext_ns | output | 30 | Nanoseconds of the capture |

## Verification
Captures are run in the four combinations of field bit 5 and live bit 5. Only the set/clear combination should subtract a field range, so a wrong polarity or an inverted test shows up at once. Distinct values in the two field halves expose a swapped or shifted splice. A capture whose live upper bits are zero forces the subtraction to wrap. Strobes without the present flag, flags without a strobe, and noise in the unused bits of the second word show whether anything but a valid capture can move the outputs.

// File: rtl/ts_sec_extend.sv
module ts_sec_extend #(
  parameter int WORD_W      = 32,
  parameter int NS_W        = 30,
  parameter int SEC_W       = 48,
  parameter int FIELD_W     = 6,
  parameter int PRESENT_BIT = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_stb,
  input  logic [WORD_W-1:0] cap_w0,
  input  logic [WORD_W-1:0] cap_w1,
  input  logic [SEC_W-1:0]  live_sec,
  output logic              ext_vld,
  output logic [SEC_W-1:0]  ext_sec,
  output logic [NS_W-1:0]   ext_ns
);
  localparam int LO_W = WORD_W - NS_W;
  localparam int HI_W = FIELD_W - LO_W;
  localparam logic [SEC_W-1:0] RANGE = {{(SEC_W-1){1'b0}}, 1'b1} << FIELD_W;

  logic [FIELD_W-1:0] field;
  logic               take;
  logic               wrap;
  logic [SEC_W-1:0]   spliced;
  logic [SEC_W-1:0]   full;

  assign field   = {cap_w1[HI_W-1:0], cap_w0[WORD_W-1:NS_W]};
  assign take    = cap_stb & cap_w1[PRESENT_BIT];
  assign wrap    = field[FIELD_W-1] & ~live_sec[FIELD_W-1];
  assign spliced = {live_sec[SEC_W-1:FIELD_W], field};
  assign full    = wrap ? spliced - RANGE : spliced;

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_vld <= 1'b0;
      ext_sec <= '0;
      ext_ns  <= '0;
    end else begin
      ext_vld <= take;
      if (take) begin
        ext_sec <= full;
        ext_ns  <= cap_w0[NS_W-1:0];
      end
    end
  end

  AST_VLD_AFTER_TAKE: assert property (@(posedge clk) disable iff (rst)
    take |=> ext_vld); // R6
  AST_NO_VLD_ELSE: assert property (@(posedge clk) disable iff (rst)
    !take |=> !ext_vld); // R6
  AST_NS_PASS: assert property (@(posedge clk) disable iff (rst)
    take |=> ext_ns == $past(cap_w0[NS_W-1:0])); // R2
  AST_FIELD_LOW: assert property (@(posedge clk) disable iff (rst)
    take |=> ext_sec[FIELD_W-1:0] == $past(field)); // R3
  AST_UPPER_KEEP: assert property (@(posedge clk) disable iff (rst)
    (take && !(cap_w0[WORD_W-1] == 1'b0 && 1'b0) && !field[FIELD_W-1]) |=>
      ext_sec[SEC_W-1:FIELD_W] == $past(live_sec[SEC_W-1:FIELD_W])); // R4
  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (rst)
    !take |=> ($stable(ext_sec) && $stable(ext_ns))); // R7
endmodule

// File: tb/ts_sec_extend_tb_top.sv
module ts_sec_extend_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cap_stb = 1'b0;
  logic [31:0] cap_w0 = '0;
  logic [31:0] cap_w1 = '0;
  logic [47:0] live_sec = '0;
  logic        ext_vld;
  logic [47:0] ext_sec;
  logic [29:0] ext_ns;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    logic        vld;
    logic [47:0] sec;
    logic [29:0] ns;
    string       tag;
  } exp_t;

  exp_t sb[$];
  logic [47:0] last_sec = '0;
  logic [29:0] last_ns = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ts_sec_extend dut_i (
    .clk(clk), .rst(rst), .cap_stb(cap_stb), .cap_w0(cap_w0),
    .cap_w1(cap_w1), .live_sec(live_sec),
    .ext_vld(ext_vld), .ext_sec(ext_sec), .ext_ns(ext_ns)
  );

  function automatic logic [47:0] model_sec(logic [31:0] w0, logic [31:0] w1, logic [47:0] live);
    logic [5:0]  f;
    logic [47:0] s;
    f = {w1[3:0], w0[31:30]};
    s = {live[47:6], f};
    if (f[5] && !live[5]) s = s - 48'd64;
    return s;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic send(logic stb, logic [31:0] w0, logic [31:0] w1, logic [47:0] live, string tag);
    exp_t e;
    @(negedge clk);
    cap_stb = stb; cap_w0 = w0; cap_w1 = w1; live_sec = live;
    e.vld = stb && w1[31];
    if (e.vld) begin
      last_sec = model_sec(w0, w1, live);
      last_ns = w0[29:0];
    end
    e.sec = last_sec; e.ns = last_ns; e.tag = tag;
    sb.push_back(e);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check({e.tag, " vld"}, 64'(ext_vld), 64'(e.vld));
        check({e.tag, " sec"}, 64'(ext_sec), 64'(e.sec));
        check({e.tag, " ns"}, 64'(ext_ns), 64'(e.ns));
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset vld", 64'(ext_vld), 64'd0);
    check("R1 reset sec", 64'(ext_sec), 64'd0);
    check("R1 reset ns", 64'(ext_ns), 64'd0);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    check("R1 first cycle vld", 64'(ext_vld), 64'd0);
    check("R1 first cycle sec", 64'(ext_sec), 64'd0);
    // R2 R3 R4: field 0x1B? use field bit5 clear: w1[3:0]=0x5, w0 top=2 -> field 0x16
    send(1, {2'b10, 30'h1234_5678}, 32'h8000_0005, 48'h0000_1234_5640, "R2 R3 R4 nowrap");
    // R5: field bit5 set, live bit5 clear
    send(1, {2'b01, 30'h3FFF_FFFF}, 32'h8000_000E, 48'h0000_0ABC_DE45, "R5 wrap");
    // R4: both bit5 set, no correction
    send(1, {2'b11, 30'h0000_0001}, 32'h8000_000F, 48'h0000_0000_0FE0, "R4 both set");
    // R4: field clear live set
    send(1, {2'b00, 30'h0002_0000}, 32'h8000_0001, 48'h0123_4567_89A3, "R4 live set");
    // R7: strobe without flag
    send(1, {2'b11, 30'h0BAD_0BAD}, 32'h0000_000F, 48'hFFFF_FFFF_FFC0, "R6 R7 no flag");
    // R7: flag without strobe
    send(0, {2'b01, 30'h0111_1111}, 32'h8000_0003, 48'h0000_0000_0100, "R6 R7 no stb");
    // R8: noise in unused bits
    send(1, {2'b10, 30'h0055_AA55}, 32'hFFFF_FFF9, 48'h0000_0000_2200, "R8 noise");
    send(1, {2'b10, 30'h0055_AA55}, 32'h8000_0009, 48'h0000_0000_2200, "R8 clean");
    // R9: subtraction wraps
    send(1, {2'b11, 30'h0000_0777}, 32'h8000_000C, 48'h0000_0000_0005, "R9 wrap modulo");
    // back to back
    send(1, {2'b00, 30'h0000_0000}, 32'h8000_0008, 48'h0000_0000_0041, "R5 b2b a");
    send(1, {2'b01, 30'h3B9A_C9FF}, 32'h8000_0002, 48'h0000_0000_0041, "R4 b2b b");
    send(0, 32'h0, 32'h0, 48'h0, "R7 idle");
    send(0, 32'h0, 32'h0, 48'h0, "R7 idle2");
    @(negedge clk);
    cap_stb = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    check("R6 queue drained", 64'(sb.size()), 64'd0);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule